// File: doc/BRIEF.md
# Slotted Latest-Available Channel Scheduler

This block books data channels for the bursts of one output port. Several source queues offer timestamped reservation requests. A round-robin arbiter admits one request per clock. From the request's timestamp, offset and length, the block computes the slot in which the burst starts and the slot in which it ends. All slot arithmetic is modulo 256 and is taken relative to the control-slot counter. Requests whose window is malformed are refused.

Every channel keeps a short queue of its booked reservations, oldest first. The horizon of a channel is the end slot of its last booking, or the current slot when its queue is empty. An accepted burst goes to the channel whose horizon is the latest one still at or before the burst's start. This leaves the smallest idle gap.

When no channel can take the burst, the block looks at the last bookings that could be displaced. It picks the one of lowest priority, and among those the shortest. The new burst takes that booking's place only if it has strictly higher priority, or equal priority and a strictly longer length. Otherwise the new burst is lost. Each booking produces a switch-setup record and a header-regeneration strobe. Each loss produces a drop record. Per-priority counters tally accepted and dropped bursts.

Top module: `slot_chan_sched`

## Requirements
- R1: `req_ready` is at most one-hot and is high only for a source whose `req_valid` is high. The search starts at the source after the last one granted, and source 0 comes first after reset.
- R2: The start slot is `ts + offset` and the end slot is `start + length`, both modulo 256. They appear on `setup_start` and `setup_end`.
- R3: A request is refused if its start equals the current slot, if its length is 0, or if (start − slot) mod 256 plus the length exceeds 127. A refusal gives `drop_valid`=1, `drop_preempt`=0 and `drop_qos` equal to the request's priority, with no setup.
- R4: A channel qualifies if its queue is not full and (horizon − slot) ≤ (start − slot) mod 256. Among the qualifying channels, the one with the largest horizon distance is chosen, and ties go to the lowest index.
- R5: The head booking of a channel is removed when the slot counter reaches its end slot, or has passed it by less than 128. An emptied channel then counts as having its horizon at the current slot.
- R6: If no channel qualifies, the candidate channels are those whose last booking has not started yet and whose previous end (or the current slot) is at or before the new start. The victim is the candidate of lowest priority, then shortest length, then lowest index. If the new burst wins, it replaces the victim on that channel. A setup is emitted together with `drop_valid`=1, `drop_preempt`=1 and `drop_qos` equal to the victim's priority.
- R7: A burst that finds no channel and does not win gives `drop_valid`=1 and `drop_preempt`=0 with its own priority, and no setup.
- R8: `regen_valid` pulses in the same cycle as `setup_valid` and never without it. `regen_src` gives the index of the granted source.
- R9: `acc_cnt` field q (bits q·CNT_W upward) counts accepted bursts of priority q. `drop_cnt` field q counts refused, lost and displaced bursts of priority q.
- R10: After reset all valid outputs are 0, all counters are 0 and no `req_ready` is raised without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_cnt | input | 8 | Current control-slot counter |
| req_valid | input | NSRC | Request present per source |
| req_ts | input | NSRC*8 | Timestamp slot per source |
| req_ofs | input | NSRC*5 | Offset in slots per source |
| req_len | input | NSRC*4 | Burst length in slots per source |
| req_qos | input | NSRC*2 | Priority per source, higher wins |
| req_ready | output | NSRC | Grant, one-hot |
| setup_valid | output | 1 | Switch-setup record valid |
| setup_ch | output | log2(NCH) | Chosen channel |
| setup_start | output | 8 | Booked start slot |
| setup_end | output | 8 | Booked end slot |
| regen_valid | output | 1 | Header regeneration strobe |
| regen_src | output | log2(NSRC) | Source of the regenerated header |
| drop_valid | output | 1 | A burst was lost |
| drop_qos | output | 2 | Priority of the lost burst |
| drop_preempt | output | 1 | Lost burst was an earlier booking |
| acc_cnt | output | 4*CNT_W | Accepted count per priority |
| drop_cnt | output | 4*CNT_W | Dropped count per priority |

## Verification
The first pattern books a burst while one channel ends early and another ends later, both before the burst's start. This tells the latest-available choice apart from a lowest-index choice, and equal horizons check the tie rule. Requests against fully blocked channels are then run at lower, equal-shorter, higher and equal-longer priority. This separates the lose cases from the two displacement cases and checks the victim order. The slot counter is then advanced past old bookings so that a burst fits only on an emptied channel, which shows retirement. A wrap across slot 255 and two simultaneous sources check the modulo arithmetic and the rotating grant.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int SLOT_W = 8;
    localparam int OFS_W  = 5;
    localparam int LEN_W  = 4;
    localparam int QOS_W  = 2;
    localparam int NQOS   = 1 << QOS_W;
    localparam int HALF   = 1 << (SLOT_W - 1);

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        slot_t             start;
        slot_t             stop;
        logic [QOS_W-1:0]  qos;
    } resv_t;
endpackage

// File: rtl/sched_rr_arb.sv
module sched_rr_arb #(
    parameter int NREQ = 4,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] gnt,
    output logic [IW-1:0]   gnt_idx
);
    logic [IW-1:0] last_q, last_d;

    always_comb begin
        logic found;
        int   idx;
        found   = 1'b0;
        gnt     = '0;
        gnt_idx = '0;
        last_d  = last_q;
        for (int i = 1; i <= NREQ; i++) begin
            idx = (int'(last_q) + i) % NREQ;
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                gnt_idx  = IW'(idx);
            end
        end
        if (found) last_d = gnt_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= IW'(NREQ - 1);
        else        last_q <= last_d;
    end
endmodule

// File: rtl/sched_req_chk.sv
module sched_req_chk
    import sched_pkg::*;
(
    input  slot_t            now,
    input  slot_t            ts,
    input  logic [OFS_W-1:0] ofs,
    input  logic [LEN_W-1:0] len,
    output slot_t            start,
    output slot_t            stop,
    output logic             ok
);
    slot_t             rs;
    logic [SLOT_W:0]   span;

    always_comb begin
        start = ts + SLOT_W'(ofs);
        stop  = start + SLOT_W'(len);
        rs    = start - now;
        span  = {1'b0, rs} + (SLOT_W+1)'(len);
        ok    = (rs != '0) && (len != '0) && (span <= (SLOT_W+1)'(HALF - 1));
    end
endmodule

// File: rtl/sched_chan_pick.sv
module sched_chan_pick
    import sched_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  slot_t                        now,
    input  slot_t                        start,
    input  slot_t [NCH-1:0]              horizon,
    input  logic  [NCH-1:0]              elig,
    input  logic  [NCH-1:0]              cand,
    input  logic  [NCH-1:0][QOS_W-1:0]   vqos,
    input  slot_t [NCH-1:0]              vlen,
    output logic                         fit,
    output logic  [CHW-1:0]              fit_ch,
    output logic                         vic,
    output logic  [CHW-1:0]              vic_ch
);
    always_comb begin
        slot_t            rs, hr, best, bl;
        logic [QOS_W-1:0] bq;
        rs     = start - now;
        fit    = 1'b0;
        fit_ch = '0;
        best   = '0;
        vic    = 1'b0;
        vic_ch = '0;
        bq     = '0;
        bl     = '0;
        for (int c = 0; c < NCH; c++) begin
            hr = horizon[c] - now;
            if (elig[c] && hr <= rs && (!fit || hr > best)) begin
                fit    = 1'b1;
                best   = hr;
                fit_ch = CHW'(c);
            end
            if (cand[c] && (!vic || vqos[c] < bq || (vqos[c] == bq && vlen[c] < bl))) begin
                vic    = 1'b1;
                bq     = vqos[c];
                bl     = vlen[c];
                vic_ch = CHW'(c);
            end
        end
    end
endmodule

// File: rtl/slot_chan_sched.sv
module slot_chan_sched
    import sched_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int NCH   = 4,
    parameter int DEPTH = 4,
    parameter int CNT_W = 16,
    localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CW  = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SLOT_W-1:0]        slot_cnt,
    input  logic [NSRC-1:0]          req_valid,
    input  logic [NSRC*SLOT_W-1:0]   req_ts,
    input  logic [NSRC*OFS_W-1:0]    req_ofs,
    input  logic [NSRC*LEN_W-1:0]    req_len,
    input  logic [NSRC*QOS_W-1:0]    req_qos,
    output logic [NSRC-1:0]          req_ready,
    output logic                     setup_valid,
    output logic [CHW-1:0]           setup_ch,
    output logic [SLOT_W-1:0]        setup_start,
    output logic [SLOT_W-1:0]        setup_end,
    output logic                     regen_valid,
    output logic [SW-1:0]            regen_src,
    output logic                     drop_valid,
    output logic [QOS_W-1:0]         drop_qos,
    output logic                     drop_preempt,
    output logic [NQOS*CNT_W-1:0]    acc_cnt,
    output logic [NQOS*CNT_W-1:0]    drop_cnt
);
    typedef struct packed {
        resv_t [NCH-1:0][DEPTH-1:0]   q;
        logic  [NCH-1:0][CW-1:0]      cnt;
        logic                         stg_vld;
        logic  [SW-1:0]               stg_src;
        slot_t                        stg_ts;
        logic  [OFS_W-1:0]            stg_ofs;
        logic  [LEN_W-1:0]            stg_len;
        logic  [QOS_W-1:0]            stg_qos;
        logic                         setup_vld;
        logic  [CHW-1:0]              setup_ch;
        slot_t                        setup_start;
        slot_t                        setup_stop;
        logic                         regen_vld;
        logic  [SW-1:0]               regen_src;
        logic                         drop_vld;
        logic  [QOS_W-1:0]            drop_qos;
        logic                         drop_pre;
        logic  [NQOS-1:0][CNT_W-1:0]  acc;
        logic  [NQOS-1:0][CNT_W-1:0]  drp;
    } st_t;

    st_t s_q, s_d;

    logic [NSRC-1:0] gnt;
    logic [SW-1:0]   gnt_idx;

    sched_rr_arb #(.NREQ(NSRC)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    slot_t new_start, new_stop;
    logic  new_ok;

    sched_req_chk u_chk_req (
        .now   (slot_cnt),
        .ts    (s_q.stg_ts),
        .ofs   (s_q.stg_ofs),
        .len   (s_q.stg_len),
        .start (new_start),
        .stop  (new_stop),
        .ok    (new_ok)
    );

    slot_t [NCH-1:0]            horizon;
    logic  [NCH-1:0]            elig;
    logic  [NCH-1:0]            cand;
    logic  [NCH-1:0]            head_done;
    logic  [NCH-1:0][QOS_W-1:0] vqos;
    slot_t [NCH-1:0]            vlen;

    // Per-channel summary of the registered queues
    always_comb begin
        resv_t tail;
        slot_t prev_end, ts_rel, hd_rel;
        for (int c = 0; c < NCH; c++) begin
            tail     = '0;
            prev_end = slot_cnt;
            for (int k = 0; k < DEPTH; k++) begin
                if (CW'(k + 1) == s_q.cnt[c]) tail = s_q.q[c][k];
                if (CW'(k + 2) == s_q.cnt[c]) prev_end = s_q.q[c][k].stop;
            end
            horizon[c]   = (s_q.cnt[c] == '0) ? slot_cnt : tail.stop;
            elig[c]      = s_q.cnt[c] < CW'(DEPTH);
            ts_rel       = tail.start - slot_cnt;
            cand[c]      = (s_q.cnt[c] != '0) && (ts_rel != '0) && (ts_rel < SLOT_W'(HALF))
                           && ((prev_end - slot_cnt) <= (new_start - slot_cnt));
            vqos[c]      = tail.qos;
            vlen[c]      = tail.stop - tail.start;
            hd_rel       = s_q.q[c][0].stop - slot_cnt;
            head_done[c] = (s_q.cnt[c] != '0) && ((hd_rel == '0) || (hd_rel >= SLOT_W'(HALF)));
        end
    end

    logic           fit, vic;
    logic [CHW-1:0] fit_ch, vic_ch;

    sched_chan_pick #(.NCH(NCH)) u_pick (
        .now     (slot_cnt),
        .start   (new_start),
        .horizon (horizon),
        .elig    (elig),
        .cand    (cand),
        .vqos    (vqos),
        .vlen    (vlen),
        .fit     (fit),
        .fit_ch  (fit_ch),
        .vic     (vic),
        .vic_ch  (vic_ch)
    );

    always_comb begin
        resv_t            nr;
        logic             wins;
        logic [QOS_W-1:0] vq;
        slot_t            vl;

        s_d           = s_q;
        s_d.setup_vld = 1'b0;
        s_d.regen_vld = 1'b0;
        s_d.drop_vld  = 1'b0;
        s_d.drop_pre  = 1'b0;

        // Stage 1: capture the granted request
        s_d.stg_vld = |gnt;
        s_d.stg_src = gnt_idx;
        s_d.stg_ts  = req_ts [gnt_idx*SLOT_W +: SLOT_W];
        s_d.stg_ofs = req_ofs[gnt_idx*OFS_W  +: OFS_W];
        s_d.stg_len = req_len[gnt_idx*LEN_W  +: LEN_W];
        s_d.stg_qos = req_qos[gnt_idx*QOS_W  +: QOS_W];

        // Retire heads whose end slot has been reached
        for (int c = 0; c < NCH; c++) begin
            if (head_done[c]) begin
                for (int k = 0; k < DEPTH - 1; k++) s_d.q[c][k] = s_q.q[c][k+1];
                s_d.q[c][DEPTH-1] = '0;
                s_d.cnt[c]        = s_q.cnt[c] - CW'(1);
            end
        end

        // Stage 2: decide the staged burst
        nr.start = new_start;
        nr.stop  = new_stop;
        nr.qos   = s_q.stg_qos;
        vq       = vqos[vic_ch];
        vl       = vlen[vic_ch];
        wins     = vic && ((s_q.stg_qos > vq) ||
                           (s_q.stg_qos == vq && SLOT_W'(s_q.stg_len) > vl));

        if (s_q.stg_vld) begin
            if (new_ok && (fit || wins)) begin
                s_d.setup_vld   = 1'b1;
                s_d.setup_ch    = fit ? fit_ch : vic_ch;
                s_d.setup_start = new_start;
                s_d.setup_stop  = new_stop;
                s_d.regen_vld   = 1'b1;
                s_d.regen_src   = s_q.stg_src;
                s_d.acc[s_q.stg_qos] = s_q.acc[s_q.stg_qos] + CNT_W'(1);
                for (int c = 0; c < NCH; c++) begin
                    if (fit && CHW'(c) == fit_ch) begin
                        for (int k = 0; k < DEPTH; k++)
                            if (CW'(k) == s_d.cnt[c]) s_d.q[c][k] = nr;
                        s_d.cnt[c] = s_d.cnt[c] + CW'(1);
                    end else if (!fit && CHW'(c) == vic_ch) begin
                        for (int k = 0; k < DEPTH; k++)
                            if (CW'(k + 1) == s_d.cnt[c]) s_d.q[c][k] = nr;
                    end
                end
                if (!fit) begin
                    s_d.drop_vld    = 1'b1;
                    s_d.drop_pre    = 1'b1;
                    s_d.drop_qos    = vq;
                    s_d.drp[vq]     = s_q.drp[vq] + CNT_W'(1);
                end
            end else begin
                s_d.drop_vld = 1'b1;
                s_d.drop_qos = s_q.stg_qos;
                s_d.drp[s_q.stg_qos] = s_q.drp[s_q.stg_qos] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready    = gnt;
    assign setup_valid  = s_q.setup_vld;
    assign setup_ch     = s_q.setup_ch;
    assign setup_start  = s_q.setup_start;
    assign setup_end    = s_q.setup_stop;
    assign regen_valid  = s_q.regen_vld;
    assign regen_src    = s_q.regen_src;
    assign drop_valid   = s_q.drop_vld;
    assign drop_qos     = s_q.drop_qos;
    assign drop_preempt = s_q.drop_pre;

    for (genvar g = 0; g < NQOS; g++) begin : g_cnt
        assign acc_cnt [g*CNT_W +: CNT_W] = s_q.acc[g];
        assign drop_cnt[g*CNT_W +: CNT_W] = s_q.drp[g];
    end
endmodule

// File: rtl/sched_checker.sv
module sched_checker
    import sched_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [SLOT_W-1:0]     slot_cnt,
    input logic [NSRC-1:0]       req_valid,
    input logic [NSRC-1:0]       req_ready,
    input logic                  setup_valid,
    input logic [SLOT_W-1:0]     setup_start,
    input logic [SLOT_W-1:0]     setup_end,
    input logic                  regen_valid,
    input logic                  drop_valid,
    input logic                  drop_preempt,
    input logic [NQOS*CNT_W-1:0] acc_cnt
);
    logic [CNT_W+1:0] acc_sum;

    always_comb begin
        acc_sum = '0;
        for (int q = 0; q < NQOS; q++) acc_sum = acc_sum + (CNT_W+2)'(acc_cnt[q*CNT_W +: CNT_W]);
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready)); // R1
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0); // R1
    AST_START_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |-> ((slot_t'(setup_start - $past(slot_cnt)) != '0) &&
                         (slot_t'(setup_start - $past(slot_cnt)) < slot_t'(HALF)))); // R3
    AST_END_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |-> (slot_t'(setup_end - $past(slot_cnt)) >
                         slot_t'(setup_start - $past(slot_cnt)))); // R2
    AST_REGEN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        regen_valid == setup_valid); // R8
    AST_NEW_FATE: assert property (@(posedge clk) disable iff (!rst_n)
        !(setup_valid && drop_valid && !drop_preempt)); // R7
    AST_PREEMPT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_valid && drop_preempt) |-> setup_valid); // R6
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sum == $past(acc_sum) + (CNT_W+2)'(setup_valid)); // R9
endmodule

bind slot_chan_sched sched_checker #(.NSRC(NSRC), .CNT_W(CNT_W)) u_sched_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_cnt     (slot_cnt),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .setup_valid  (setup_valid),
    .setup_start  (setup_start),
    .setup_end    (setup_end),
    .regen_valid  (regen_valid),
    .drop_valid   (drop_valid),
    .drop_preempt (drop_preempt),
    .acc_cnt      (acc_cnt)
);

// File: tb/slot_chan_sched_test.sv
`timescale 1ns/1ps
module slot_chan_sched_test;
    localparam int NSRC = 4, NCH = 4, DEPTH = 4, CNT_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        slot_cnt = 8'd10;
    logic [NSRC-1:0]   req_valid = '0;
    logic [NSRC*8-1:0] req_ts = '0;
    logic [NSRC*5-1:0] req_ofs = '0;
    logic [NSRC*4-1:0] req_len = '0;
    logic [NSRC*2-1:0] req_qos = '0;
    logic [NSRC-1:0]   req_ready;
    logic              setup_valid, regen_valid, drop_valid, drop_preempt;
    logic [1:0]        setup_ch, regen_src, drop_qos;
    logic [7:0]        setup_start, setup_end;
    logic [4*CNT_W-1:0] acc_cnt, drop_cnt;

    slot_chan_sched #(.NSRC(NSRC), .NCH(NCH), .DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .slot_cnt(slot_cnt),
        .req_valid(req_valid), .req_ts(req_ts), .req_ofs(req_ofs),
        .req_len(req_len), .req_qos(req_qos), .req_ready(req_ready),
        .setup_valid(setup_valid), .setup_ch(setup_ch),
        .setup_start(setup_start), .setup_end(setup_end),
        .regen_valid(regen_valid), .regen_src(regen_src),
        .drop_valid(drop_valid), .drop_qos(drop_qos), .drop_preempt(drop_preempt),
        .acc_cnt(acc_cnt), .drop_cnt(drop_cnt)
    );

    always #2 clk = ~clk;

    typedef struct {
        bit    is_drop;
        int    ch, st, en, src, qos, pre;
        string tag;
    } exp_t;

    exp_t expq[$];
    int   nchk = 0, nerr = 0;
    bit   done = 0;

    task automatic chk(input string tag, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic exp_setup(input int ch, input int st, input int en, input int src, input string tag);
        exp_t e;
        e.is_drop = 0; e.ch = ch; e.st = st; e.en = en; e.src = src;
        e.qos = 0; e.pre = 0; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic exp_drop(input int qos, input int pre, input string tag);
        exp_t e;
        e.is_drop = 1; e.ch = 0; e.st = 0; e.en = 0; e.src = 0;
        e.qos = qos; e.pre = pre; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic load(input int src, input int ts, input int ofs, input int len, input int qos);
        req_ts [src*8 +: 8] = 8'(ts);
        req_ofs[src*5 +: 5] = 5'(ofs);
        req_len[src*4 +: 4] = 4'(len);
        req_qos[src*2 +: 2] = 2'(qos);
    endtask

    task automatic send(input int src, input int ts, input int ofs, input int len, input int qos);
        @(negedge clk);
        load(src, ts, ofs, len, qos);
        req_valid[src] = 1'b1;
        #1;
        while (!req_ready[src]) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid[src] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic step_to(input int target);
        while (slot_cnt != 8'(target)) begin
            @(negedge clk);
            slot_cnt = slot_cnt + 8'd1;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_cnt(input string tag, input int a0, input int a1, input int a2, input int a3,
                           input int d0, input int d1, input int d2, input int d3);
        chk({tag, " acc q0"}, int'(acc_cnt[0*CNT_W +: CNT_W]), a0);
        chk({tag, " acc q1"}, int'(acc_cnt[1*CNT_W +: CNT_W]), a1);
        chk({tag, " acc q2"}, int'(acc_cnt[2*CNT_W +: CNT_W]), a2);
        chk({tag, " acc q3"}, int'(acc_cnt[3*CNT_W +: CNT_W]), a3);
        chk({tag, " drop q0"}, int'(drop_cnt[0*CNT_W +: CNT_W]), d0);
        chk({tag, " drop q1"}, int'(drop_cnt[1*CNT_W +: CNT_W]), d1);
        chk({tag, " drop q2"}, int'(drop_cnt[2*CNT_W +: CNT_W]), d2);
        chk({tag, " drop q3"}, int'(drop_cnt[3*CNT_W +: CNT_W]), d3);
    endtask

    // Monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (regen_valid && !setup_valid) chk("R8 regen without setup", 1, 0);
            if (setup_valid) begin
                if (expq.size() == 0) chk("R7 unexpected setup", 1, 0);
                else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk({e.tag, " kind"}, 0, int'(e.is_drop));
                    chk({e.tag, " channel"}, int'(setup_ch), e.ch);
                    chk({e.tag, " start R2"}, int'(setup_start), e.st);
                    chk({e.tag, " end R2"}, int'(setup_end), e.en);
                    chk("R8 regen strobe", int'(regen_valid), 1);
                    chk("R8 regen source", int'(regen_src), e.src);
                end
            end
            if (drop_valid) begin
                if (expq.size() == 0) chk("R7 unexpected drop", 1, 0);
                else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk({e.tag, " kind"}, 1, int'(e.is_drop));
                    chk({e.tag, " drop qos"}, int'(drop_qos), e.qos);
                    chk({e.tag, " preempt flag"}, int'(drop_preempt), e.pre);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            chk("watchdog expired", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 setup_valid", int'(setup_valid), 0);
        chk("R10 drop_valid", int'(drop_valid), 0);
        chk("R10 regen_valid", int'(regen_valid), 0);
        chk("R10 ready idle", int'(req_ready), 0);
        chk_cnt("R10", 0, 0, 0, 0, 0, 0, 0, 0);

        // slot 10: build per-channel horizons
        exp_setup(0, 30, 40, 0, "R4 empty tie A");      send(0, 10, 20, 10, 1);
        exp_setup(1, 11, 13, 1, "R4 next free B");      send(1, 10, 1, 2, 1);
        exp_setup(2, 11, 17, 2, "R4 next free C");      send(2, 10, 1, 6, 1);
        exp_setup(2, 20, 23, 3, "R4 latest horizon D"); send(3, 10, 10, 3, 0);
        exp_setup(3, 12, 13, 0, "R4 only empty E");     send(0, 10, 2, 1, 2);
        exp_setup(1, 15, 17, 1, "R4 tie lowest F");     send(1, 10, 5, 2, 0);

        // R3 refusals
        exp_drop(2, 0, "R3 start at now");   send(2, 10, 0, 3, 2);
        exp_drop(1, 0, "R3 zero length");    send(2, 10, 3, 0, 1);
        exp_drop(3, 0, "R3 window overrun"); send(3, 110, 20, 10, 3);

        // contention at start 12
        exp_drop(0, 0, "R7 lower qos loses");        send(3, 10, 2, 1, 0);
        exp_drop(1, 0, "R7 equal qos shorter loses"); send(3, 10, 2, 5, 1);
        exp_setup(0, 12, 15, 2, "R6 higher qos takes victim");
        exp_drop(1, 1, "R6 victim lowest qos");      send(2, 10, 2, 3, 2);
        exp_setup(3, 12, 14, 1, "R6 equal qos longer wins");
        exp_drop(2, 1, "R6 victim shortest");        send(1, 10, 2, 2, 2);
        chk_cnt("R9 after contention", 2, 3, 3, 0, 1, 3, 2, 1);

        // R5 retirement: only emptied channels can take the burst
        step_to(18);
        exp_setup(0, 19, 20, 0, "R5 retired channel reused"); send(0, 18, 1, 1, 0);

        // R2 wrap across 255
        step_to(250);
        exp_setup(0, 253, 7, 2, "R2 wrap"); send(2, 250, 3, 10, 3);

        // R1 round robin: last grant was source 2
        exp_setup(1, 255, 1, 3, "R1 first grant src3");
        exp_setup(2, 0, 2, 1, "R1 second grant src1");
        @(negedge clk);
        load(3, 250, 5, 2, 0);
        load(1, 250, 6, 2, 0);
        req_valid[3] = 1'b1;
        req_valid[1] = 1'b1;
        #1;
        chk("R1 rotate to src3", int'(req_ready), 8);
        @(negedge clk);
        req_valid[3] = 1'b0;
        #1;
        chk("R1 then src1", int'(req_ready), 2);
        @(negedge clk);
        req_valid[1] = 1'b0;
        repeat (6) @(negedge clk);

        chk("R7 all expected outputs seen", expq.size(), 0);
        chk_cnt("R9 final", 5, 3, 3, 1, 1, 3, 2, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule